// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver with 8-bit or 9-bit frames. It sits behind a byte-wide register port with four locations. Software writes bytes to be sent and reads bytes that arrived. It sets the operating mode and watches completion and error status through one shared control/status location. An external tick at sixteen times the bit rate paces both shift engines.

In 9-bit multiprocessor operation, a frame whose ninth bit is 1 is an address frame. A listening node stays asleep until an address frame matches its own address, where only the bit positions selected by a mask are compared, or carries the broadcast value 0xFF. While asleep it discards data frames. The block also records three error conditions. Each is kept in a sticky flag that raises no interrupt:

- writing a new byte while a frame is still being sent,
- a new byte arriving before the previous one was read,
- a stop bit sampled low.

On a write, the three error-flag positions of the control/status location select the operating mode instead.

Top module: `mp_uart`

## Requirements
- R1: After reset, txd is high, rx_irq and tx_irq are low, and the control/status location (address 1) reads 0x00. The other locations are: data at address 0 (write sends, read returns the last accepted byte), own address at 2, and compare mask at 3, whose reset value is 0xFF.
- R2: Writing address 0 while the transmitter is idle sends these bits on txd, each held for 16 ticks: a low start bit, the 8 data bits LSB first, then (in 9-bit mode only) control bit 2 as the ninth bit, then a high stop bit. After the stop bit, control bit 1 (transmit complete) is set and tx_irq follows it.
- R3: A write to address 0 during a transmission sets control bit 7 (collision), leaves the frame in flight unchanged, and does not raise tx_irq.
- R4: A receive frame starts only on a high-to-low change of rxd seen at a tick. A start bit found high again 8 ticks later is dropped, and no byte is accepted.
- R5: An accepted frame puts its byte at address 0 and its ninth bit at control bit 3 (0 in 8-bit mode), and sets control bit 0 (receive complete). rx_irq follows control bit 0.
- R6: A byte accepted while the previous one has not been read from address 0 sets control bit 6 (overrun). The new byte replaces the old one.
- R7: A completed frame with a low stop bit sets control bit 5 (frame error). The byte is still accepted.
- R8: All status flags are sticky. Writing 1 to control bit 0 or bit 1 clears that flag. Writing 1 to control bit 4 clears bits 5, 6 and 7. Reading does not clear them.
- R9: A write to control bits 5, 6 and 7 sets 9-bit mode, receiver enable and multiprocessor enable respectively. Reads of those bits return only the error flags. With the receiver disabled, frames are ignored.
- R10: With 9-bit and multiprocessor modes on, data frames (ninth bit 0) are discarded until an address frame matches. A match means the received byte equals the own address on every bit where the mask is 1.
- R11: With multiprocessor mode on, an address frame of 0xFF is accepted whatever the own address and mask, and wakes the node.
- R12: An address frame that does not match puts the node back to sleep, so later data frames are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe at 16x the bit rate |
| addr | input | 2 | Register location select |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (marks the data byte as read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rx_irq | output | 1 | Receive-complete interrupt |
| tx_irq | output | 1 | Transmit-complete interrupt |

## Verification
The transmitter is driven with an 8-bit byte, a 9-bit byte with the ninth bit set, and a second write landing mid-frame. A reference model compares the line and tx_irq every clock, so a wrong bit order, bit length, ninth bit or a collision that disturbs the frame is told apart from correct shifting. The receiver gets clean frames, a back-to-back pair left unread, a low stop bit, a short start glitch, and a frame while disabled. Together these separate overrun from frame error, and glitch rejection from the enable gate. In multiprocessor mode, the receiver is fed a sequence of data, masked-match, mismatch and broadcast frames, which tells sleeping, waking and re-sleeping apart.

// File: rtl/mp_uart_pkg.sv
`timescale 1ns/1ps
package mp_uart_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP} rx_state_e;

  typedef struct packed {
    logic nine;
    logic rx_en;
    logic mp_en;
  } mode_t;

  localparam logic [1:0] A_DATA  = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_SADDR = 2'd2;
  localparam logic [1:0] A_MASK  = 2'd3;

  localparam int B_RXC  = 0;
  localparam int B_TXC  = 1;
  localparam int B_TX9  = 2;
  localparam int B_RX9  = 3;
  localparam int B_ECLR = 4;
  localparam int B_FE   = 5;
  localparam int B_OVR  = 6;
  localparam int B_COL  = 7;
endpackage

// File: rtl/mp_uart_match.sv
`timescale 1ns/1ps
module mp_uart_match
  import mp_uart_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic [W-1:0] frame,
  input  logic [W-1:0] own,
  input  logic [W-1:0] care,
  output logic         hit
);
  logic masked_eq;
  logic bcast;

  assign masked_eq = ((frame ^ own) & care) == '0;
  assign bcast     = &frame;
  assign hit       = masked_eq | bcast;
endmodule

// File: rtl/mp_uart_tx.sv
`timescale 1ns/1ps
module mp_uart_tx
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              send_req,
  input  logic              nine_mode,
  input  logic              ninth_bit,
  input  logic [BYTE_W-1:0] din,
  output logic              txd,
  output logic              busy,
  output logic              done,
  output logic              collide
);
  localparam int CW = $clog2(OSR);
  localparam int FW = BYTE_W + 3;
  localparam int IW = $clog2(FW);
  localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [IW-1:0] last_q, last_d;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    last_d = last_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (send_req) begin
        busy_d = 1'b1;
        cnt_d  = '0;
        idx_d  = '0;
        if (nine_mode) begin
          sh_d   = {1'b1, ninth_bit, din, 1'b0};
          last_d = IW'(FW - 1);
        end else begin
          sh_d   = {2'b11, din, 1'b0};
          last_d = IW'(FW - 2);
        end
      end
    end else if (tick) begin
      if (cnt_q == LAST_TICK) begin
        cnt_d = '0;
        sh_d  = {1'b1, sh_q[FW-1:1]};
        if (idx_q == last_q) begin
          busy_d = 1'b0;
          done   = 1'b1;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      last_q <= last_d;
    end
  end

  assign txd     = busy_q ? sh_q[0] : 1'b1;
  assign busy    = busy_q;
  assign collide = send_req & busy_q;

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> !txd);

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy_q && txd));

  // R3
  frame_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && send_req && !tick) |=> $stable(sh_q));
endmodule

// File: rtl/mp_uart_rx.sv
`timescale 1ns/1ps
module mp_uart_rx
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxd,
  input  logic              enable,
  input  logic              nine_mode,
  output logic              frame_done,
  output logic [BYTE_W-1:0] frame_data,
  output logic              frame_bit9,
  output logic              stop_ok
);
  localparam int CW = $clog2(OSR);
  localparam int SW = BYTE_W + 1;
  localparam int IW = $clog2(SW + 1);
  localparam logic [CW-1:0] MID       = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          rxs;
  logic          prev_q, prev_d;
  rx_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [IW-1:0] idx_q, idx_d;
  logic [SW-1:0] sh_q, sh_d;
  logic          nine_q, nine_d;
  logic [IW-1:0] last_idx;

  assign rxs      = sync_q[1];
  assign last_idx = nine_q ? IW'(SW - 1) : IW'(SW - 2);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    sh_d       = sh_q;
    nine_d     = nine_q;
    prev_d     = tick ? rxs : prev_q;
    frame_done = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (tick && enable && prev_q && !rxs) begin
          st_d   = RX_START;
          cnt_d  = '0;
          nine_d = nine_mode;
        end
      end
      RX_START: begin
        if (tick) begin
          if (cnt_q == MID) begin
            cnt_d = '0;
            idx_d = '0;
            st_d  = rxs ? RX_IDLE : RX_BITS;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      RX_BITS: begin
        if (tick) begin
          if (cnt_q == LAST_TICK) begin
            cnt_d = '0;
            sh_d  = {rxs, sh_q[SW-1:1]};
            if (idx_q == last_idx) begin
              st_d = RX_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
        if (tick) begin
          if (cnt_q == LAST_TICK) begin
            frame_done = 1'b1;
            st_d       = RX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      nine_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd};
      prev_q <= prev_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      nine_q <= nine_d;
    end
  end

  assign frame_data = nine_q ? sh_q[BYTE_W-1:0] : sh_q[SW-1:1];
  assign frame_bit9 = nine_q & sh_q[SW-1];
  assign stop_ok    = rxs;

  // R4
  start_confirm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_BITS && $past(st_q) == RX_START) |-> !$past(rxs));

  // R7
  done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> st_q == RX_IDLE);
endmodule

// File: rtl/mp_uart.sv
`timescale 1ns/1ps
module mp_uart
  import mp_uart_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata,
  input  logic              rxd,
  output logic              txd,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic wr_data, wr_ctrl, wr_saddr, wr_mask, rd_data;
  assign wr_data  = wr_en & (addr == A_DATA);
  assign wr_ctrl  = wr_en & (addr == A_CTRL);
  assign wr_saddr = wr_en & (addr == A_SADDR);
  assign wr_mask  = wr_en & (addr == A_MASK);
  assign rd_data  = rd_en & (addr == A_DATA);

  mode_t             mode_q, mode_d;
  logic [BYTE_W-1:0] rxbuf_q, rxbuf_d, saddr_q, saddr_d, mask_q, mask_d;
  logic              rx9_q, rx9_d, tx9_q, tx9_d;
  logic              rxc_q, rxc_d, txc_q, txc_d;
  logic              fe_q, fe_d, ovr_q, ovr_d, col_q, col_d;
  logic              unread_q, unread_d, awake_q, awake_d;

  logic              tx_busy, tx_done, tx_collide;
  logic              rx_done, rx_bit9, rx_stop_ok, addr_hit;
  logic [BYTE_W-1:0] rx_data;
  logic              mp_on, accept, err_clr;

  mp_uart_tx #(.OSR(OSR)) u_tx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .tick      (tick),
    .send_req  (wr_data),
    .nine_mode (mode_q.nine),
    .ninth_bit (tx9_q),
    .din       (wdata),
    .txd       (txd),
    .busy      (tx_busy),
    .done      (tx_done),
    .collide   (tx_collide)
  );

  mp_uart_rx #(.OSR(OSR)) u_rx (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .tick       (tick),
    .rxd        (rxd),
    .enable     (mode_q.rx_en),
    .nine_mode  (mode_q.nine),
    .frame_done (rx_done),
    .frame_data (rx_data),
    .frame_bit9 (rx_bit9),
    .stop_ok    (rx_stop_ok)
  );

  mp_uart_match #(.W(BYTE_W)) u_match (
    .frame (rx_data),
    .own   (saddr_q),
    .care  (mask_q),
    .hit   (addr_hit)
  );

  assign mp_on   = mode_q.mp_en & mode_q.nine;
  assign accept  = rx_done & (~mp_on | (rx_bit9 ? addr_hit : awake_q));
  assign err_clr = wr_ctrl & wdata[B_ECLR];

  always_comb begin
    mode_d   = mode_q;
    rxbuf_d  = rxbuf_q;
    saddr_d  = wr_saddr ? wdata : saddr_q;
    mask_d   = wr_mask  ? wdata : mask_q;
    rx9_d    = rx9_q;
    tx9_d    = tx9_q;
    rxc_d    = rxc_q;
    txc_d    = txc_q;
    fe_d     = fe_q;
    ovr_d    = ovr_q;
    col_d    = col_q;
    unread_d = unread_q;
    awake_d  = mp_on ? awake_q : 1'b0;

    if (wr_ctrl) begin
      tx9_d  = wdata[B_TX9];
      mode_d = '{nine: wdata[B_FE], rx_en: wdata[B_OVR], mp_en: wdata[B_COL]};
      if (wdata[B_RXC]) rxc_d = 1'b0;
      if (wdata[B_TXC]) txc_d = 1'b0;
    end
    if (err_clr) begin
      fe_d  = 1'b0;
      ovr_d = 1'b0;
      col_d = 1'b0;
    end
    if (rd_data) unread_d = 1'b0;

    if (rx_done && mp_on && rx_bit9) awake_d = addr_hit;
    if (rx_done && !rx_stop_ok) fe_d = 1'b1;
    if (accept) begin
      rxbuf_d  = rx_data;
      rx9_d    = rx_bit9;
      rxc_d    = 1'b1;
      unread_d = 1'b1;
      if (unread_q && !rd_data) ovr_d = 1'b1;
    end
    if (tx_collide) col_d = 1'b1;
    if (tx_done)    txc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      mode_q   <= '0;
      rxbuf_q  <= '0;
      saddr_q  <= '0;
      mask_q   <= '1;
      rx9_q    <= 1'b0;
      tx9_q    <= 1'b0;
      rxc_q    <= 1'b0;
      txc_q    <= 1'b0;
      fe_q     <= 1'b0;
      ovr_q    <= 1'b0;
      col_q    <= 1'b0;
      unread_q <= 1'b0;
      awake_q  <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      rxbuf_q  <= rxbuf_d;
      saddr_q  <= saddr_d;
      mask_q   <= mask_d;
      rx9_q    <= rx9_d;
      tx9_q    <= tx9_d;
      rxc_q    <= rxc_d;
      txc_q    <= txc_d;
      fe_q     <= fe_d;
      ovr_q    <= ovr_d;
      col_q    <= col_d;
      unread_q <= unread_d;
      awake_q  <= awake_d;
    end
  end

  logic [BYTE_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view         = '0;
    ctrl_view[B_RXC]  = rxc_q;
    ctrl_view[B_TXC]  = txc_q;
    ctrl_view[B_TX9]  = tx9_q;
    ctrl_view[B_RX9]  = rx9_q;
    ctrl_view[B_FE]   = fe_q;
    ctrl_view[B_OVR]  = ovr_q;
    ctrl_view[B_COL]  = col_q;
    case (addr)
      A_DATA:  rdata = rxbuf_q;
      A_CTRL:  rdata = ctrl_view;
      A_SADDR: rdata = saddr_q;
      default: rdata = mask_q;
    endcase
  end

  assign rx_irq = rxc_q;
  assign tx_irq = txc_q;

  // R3
  col_cause_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(col_q) |-> $past(wr_en && addr == A_DATA));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (accept && unread_q && !rd_data) |=> ovr_q);

  // R8
  fe_sticky_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (fe_q && !err_clr) |=> fe_q);

  // R11
  bcast_wake_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (rx_done && mp_on && rx_bit9 && rx_data == 8'hFF) |=> (rxc_q && awake_q));
endmodule

// File: tb/mp_uart_tb.sv
`timescale 1ns/1ps
module mp_uart_tb;
  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd, rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;

  mp_uart #(.OSR(OSR)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .rxd(rxd), .txd(txd),
    .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd2);
  end

  // Behavioural transmit model: queue of line levels, tick count, flag.
  int  mq[$];
  int  m_cnt = 0;
  bit  m_txc = 1'b0;
  bit  m_nine = 1'b0;
  bit  m_tx9 = 1'b0;
  bit  m_busy;
  bit  mdl_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete();
      m_cnt = 0;
      m_txc = 1'b0;
      m_nine = 1'b0;
      m_tx9 = 1'b0;
    end else begin
      m_busy = (mq.size() != 0);
      if (wr_en && addr == 2'd1) begin
        if (wdata[1]) m_txc = 1'b0;
        m_nine = wdata[5];
        m_tx9  = wdata[2];
      end
      if (m_busy && tick) begin
        m_cnt++;
        if (m_cnt == OSR) begin
          m_cnt = 0;
          void'(mq.pop_front());
          if (mq.size() == 0) m_txc = 1'b1;
        end
      end
      if (wr_en && addr == 2'd0 && !m_busy) begin
        mq.push_back(0);
        for (int i = 0; i < 8; i++) mq.push_back(int'(wdata[i]));
        if (m_nine) mq.push_back(int'(m_tx9));
        mq.push_back(1);
        m_cnt = 0;
      end
    end
  end

  // R2: line and tx_irq compared with the model every clock
  always @(negedge clk) begin
    if (mdl_on) begin
      int expv;
      expv = (mq.size() != 0) ? mq[0] : 1;
      checks++;
      if (txd !== expv[0]) begin
        errors++;
        $display("FAIL R2 txd: actual=%b expected=%b at %0t", txd, expv[0], $time);
      end
      checks++;
      if (tx_irq !== m_txc) begin
        errors++;
        $display("FAIL R2 tx_irq: actual=%b expected=%b at %0t", tx_irq, m_txc, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_ticks(input int n);
    for (int i = 0; i < n;) begin
      @(posedge clk);
      if (tick) i++;
    end
  endtask

  task automatic send(input logic [7:0] d, input bit use9, input bit b9, input bit stopv);
    @(negedge clk); rxd = 1'b0; wait_ticks(OSR);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); rxd = d[i]; wait_ticks(OSR);
    end
    if (use9) begin
      @(negedge clk); rxd = b9; wait_ticks(OSR);
    end
    @(negedge clk); rxd = stopv; wait_ticks(OSR);
    @(negedge clk); rxd = 1'b1; wait_ticks(4);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mdl_on = 1'b1;

    // R1 reset state
    rd(2'd1, v); chk("R1 ctrl after reset", v, 8'h00);
    chk("R1 txd idle", {7'd0, txd}, 8'h01);
    chk("R1 irqs low", {6'd0, rx_irq, tx_irq}, 8'h00);
    rd(2'd3, v); chk("R1 mask reset", v, 8'hFF);

    // R2 8-bit transmit
    wr(2'd1, 8'h40);
    wr(2'd0, 8'hA5);
    wait_ticks(OSR * 10 + 4);
    rd(2'd1, v); chk("R2 txc after frame", v, 8'h02);
    chk("R2 tx_irq", {7'd0, tx_irq}, 8'h01);
    wr(2'd1, 8'h42);
    rd(2'd1, v); chk("R8 txc cleared", v, 8'h00);

    // R3 collision
    wr(2'd0, 8'h3C);
    wait_ticks(20);
    wr(2'd0, 8'hFF);
    chk("R3 no tx_irq on collision", {7'd0, tx_irq}, 8'h00);
    rd(2'd1, v); chk("R3 collision flag mid-frame", v, 8'h80);
    wait_ticks(OSR * 10);
    rd(2'd1, v); chk("R3 collision and txc", v, 8'h82);
    wr(2'd1, 8'h52);
    rd(2'd1, v); chk("R8 error clear", v, 8'h00);

    // R5 receive
    send(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R5 rx status", v, 8'h01);
    chk("R5 rx_irq", {7'd0, rx_irq}, 8'h01);
    rd(2'd0, v); chk("R5 rx data", v, 8'h5A);
    rd(2'd1, v); chk("R8 rxc sticky after read", v, 8'h01);
    wr(2'd1, 8'h41);
    rd(2'd1, v); chk("R8 rxc cleared", v, 8'h00);

    // R6 overrun
    send(8'h11, 1'b0, 1'b0, 1'b1);
    send(8'h22, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R6 overrun flag", v, 8'h41);
    rd(2'd0, v); chk("R6 newest byte kept", v, 8'h22);
    wr(2'd1, 8'h51);
    rd(2'd1, v); chk("R8 overrun cleared", v, 8'h00);

    // R7 frame error
    send(8'h77, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); chk("R7 frame error flag", v, 8'h21);
    rd(2'd0, v); chk("R7 byte still accepted", v, 8'h77);
    wr(2'd1, 8'h51);

    // R4 start glitch
    @(negedge clk); rxd = 1'b0; wait_ticks(3);
    @(negedge clk); rxd = 1'b1; wait_ticks(OSR * 2);
    rd(2'd1, v); chk("R4 glitch rejected", v, 8'h00);
    chk("R4 no rx_irq", {7'd0, rx_irq}, 8'h00);

    // R9 receiver disabled, mode bits not read back
    wr(2'd1, 8'h00);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R9 receiver off", v, 8'h00);
    wr(2'd1, 8'hE0);
    rd(2'd1, v); chk("R9 mode write not read as flags", v, 8'h00);

    // R10..R12 multiprocessor
    wr(2'd2, 8'h42);
    wr(2'd3, 8'hF0);
    send(8'h99, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); chk("R10 data ignored while asleep", v, 8'h00);
    send(8'h47, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); chk("R10 masked address match", v, 8'h09);
    rd(2'd0, v); chk("R10 address byte", v, 8'h47);
    wr(2'd1, 8'hE1);
    send(8'h55, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); chk("R10 data after wake", v, 8'h01);
    rd(2'd0, v); chk("R10 data byte", v, 8'h55);
    wr(2'd1, 8'hE1);
    send(8'h13, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); chk("R12 mismatch ignored", v, 8'h00);
    send(8'h66, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); chk("R12 data ignored after sleep", v, 8'h00);
    send(8'hFF, 1'b1, 1'b1, 1'b1);
    rd(2'd1, v); chk("R11 broadcast accepted", v, 8'h09);
    rd(2'd0, v); chk("R11 broadcast byte", v, 8'hFF);
    wr(2'd1, 8'hE1);
    send(8'h21, 1'b1, 1'b0, 1'b1);
    rd(2'd1, v); chk("R11 data after broadcast", v, 8'h01);
    rd(2'd0, v); chk("R11 data byte", v, 8'h21);
    wr(2'd1, 8'hE1);

    // R2 nine-bit transmit with ninth bit set
    wr(2'd1, 8'hE4);
    rd(2'd1, v); chk("R2 tx9 readback", v, 8'h04);
    wr(2'd0, 8'h81);
    wait_ticks(OSR * 11 + 4);
    rd(2'd1, v); chk("R2 nine-bit txc", v, 8'h06);
    wr(2'd1, 8'hE6);
    rd(2'd1, v); chk("R8 txc cleared nine-bit", v, 8'h04);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule